// File: doc/BRIEF.md
# Saturating Signed Add/Subtract Unit with Sticky Overflow Flag

This block does signed two's-complement arithmetic that clamps instead of wrapping. Each strobed request picks addition or subtraction of two operands. As an option, the second operand is doubled first. The first operand is always the minuend. The result and a one-cycle saturation pulse are registered, so they appear on the clock edge that samples the request.

Clamping can happen at two points. The doubling of the second operand can overflow, in which case the doubled value is clamped. The final add or subtract can also overflow. Either event raises the pulse and sets a sticky overflow flag. Overflow only ever sets this flag. A dedicated clear input resets it. If a set and a clear arrive in the same cycle, the set wins.

Top module: `sat_alu`

## Requirements
- R1: With `dbl_i`=0 and `sub_i`=0, a request whose true sum fits in W signed bits gives `result_o` = a+b and `sat_o`=0.
- R2: With `dbl_i`=0 and `sub_i`=1, a request whose true difference fits gives `result_o` = a−b (first operand minus second) and `sat_o`=0.
- R3: An addition overflows when the wrapped sum's sign differs from both addends' signs. On overflow, a negative wrapped sum yields 0x7FFFFFFF and a non-negative one yields 0x80000000, with `sat_o`=1.
- R4: A subtraction overflows when the operands' signs differ and the wrapped difference's sign differs from the first operand's sign. On overflow the result clamps by the same rule as R3, with `sat_o`=1.
- R5: With `dbl_i`=1, the second operand is replaced by 2·b before the add or subtract. When 2·b fits, no extra saturation occurs.
- R6: With `dbl_i`=1, if 2·b overflows, the doubled value clamps (0x7FFFFFFF when b is positive, 0x80000000 when negative), `sat_o`=1, and the add/subtract then uses the clamped value and may clamp again.
- R7: `result_o` and `sat_o` update on the clock edge that samples `valid_i`=1. `sat_o` is 0 after any edge where `valid_i`=0.
- R8: `q_o` is set by any saturation and stays set through later requests and idle cycles until cleared.
- R9: `q_clr_i`=1 clears `q_o` on the next edge, unless a saturation occurs on that same edge, in which case `q_o` is 1.
- R10: While `rst_ni` is low, `result_o`=0, `sat_o`=0 and `q_o`=0.
- R11: On an edge with `valid_i`=0, `result_o` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| a_i | input | W | First operand (minuend) |
| b_i | input | W | Second operand |
| dbl_i | input | 1 | 1 = double the second operand first |
| sub_i | input | 1 | 0 = add, 1 = subtract |
| q_clr_i | input | 1 | Clear the sticky flag |
| result_o | output | W | Registered saturated result |
| sat_o | output | 1 | Registered pulse: this request saturated |
| q_o | output | 1 | Sticky overflow flag |

## Verification
The assertions assume that operand, mode and clear inputs are settled well before each sampling edge. They also assume that `valid_i` is low throughout reset, since the pulse checks compare against the previous cycle's strobe. The bench changes every input on the falling clock edge and holds the strobe low while reset is applied. It raises the strobe for exactly one rising edge per request. Clear requests are made both on idle cycles and together with a saturating request, so that both branches of the set-over-clear rule are exercised.

// File: rtl/sat_pkg.sv
package sat_pkg;
  localparam int unsigned SAT_DEF_W = 32;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } addsub_e;
endpackage

// File: rtl/sat_doubler.sv
module sat_doubler #(
  parameter int unsigned W = sat_pkg::SAT_DEF_W
) (
  input  logic [W-1:0] val_i,
  input  logic         en_i,
  output logic [W-1:0] val_o,
  output logic         sat_o
);
  localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] shl;
  logic         ovf;

  always_comb begin
    shl = {val_i[W-2:0], 1'b0};
    // doubling overflows when the top two bits disagree
    ovf = val_i[W-1] ^ val_i[W-2];
    sat_o = en_i & ovf;
    if (!en_i)      val_o = val_i;
    else if (!ovf)  val_o = shl;
    else            val_o = shl[W-1] ? MAX_POS : MIN_NEG;
  end
endmodule

// File: rtl/sat_addsub.sv
module sat_addsub #(
  parameter int unsigned W = sat_pkg::SAT_DEF_W
) (
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  input  sat_pkg::addsub_e op_i,
  output logic [W-1:0]     res_o,
  output logic             sat_o
);
  import sat_pkg::*;

  localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] rhs;
  logic [W-1:0] wrap;
  logic         ovf;

  always_comb begin
    rhs  = (op_i == OP_SUB) ? ~b_i : b_i;
    wrap = a_i + rhs + {{(W-1){1'b0}}, (op_i == OP_SUB)};
    if (op_i == OP_SUB)
      ovf = (a_i[W-1] ^ b_i[W-1]) & (a_i[W-1] ^ wrap[W-1]);
    else
      ovf = (a_i[W-1] ^ wrap[W-1]) & (b_i[W-1] ^ wrap[W-1]);
    sat_o = ovf;
    if (!ovf)             res_o = wrap;
    else if (wrap[W-1])   res_o = MAX_POS;
    else                  res_o = MIN_NEG;
  end
endmodule

// File: rtl/sat_qflag.sv
module sat_qflag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;   // set beats clear
    else if (clr_i)  q_o <= 1'b0;
  end
endmodule

// File: rtl/sat_alu.sv
module sat_alu #(
  parameter int unsigned W = sat_pkg::SAT_DEF_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         dbl_i,
  input  logic         sub_i,
  input  logic         q_clr_i,
  output logic [W-1:0] result_o,
  output logic         sat_o,
  output logic         q_o
);
  import sat_pkg::*;

  logic [W-1:0] b_eff;
  logic         dbl_sat;
  logic [W-1:0] res_d;
  logic         op_sat;
  logic         any_sat;
  addsub_e      op;

  assign op = sub_i ? OP_SUB : OP_ADD;

  sat_doubler #(.W(W)) u_dbl (
    .val_i (b_i),
    .en_i  (dbl_i),
    .val_o (b_eff),
    .sat_o (dbl_sat)
  );

  sat_addsub #(.W(W)) u_as (
    .a_i   (a_i),
    .b_i   (b_eff),
    .op_i  (op),
    .res_o (res_d),
    .sat_o (op_sat)
  );

  assign any_sat = valid_i & (dbl_sat | op_sat);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      sat_o    <= 1'b0;
    end else begin
      sat_o <= any_sat;
      if (valid_i) result_o <= res_d;
    end
  end

  sat_qflag u_q (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (any_sat),
    .clr_i  (q_clr_i),
    .q_o    (q_o)
  );
endmodule

// File: rtl/sat_alu_chk.sv
module sat_alu_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         valid_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic         dbl_i,
  input logic         sub_i,
  input logic         q_clr_i,
  input logic [W-1:0] result_o,
  input logic         sat_o,
  input logic         q_o
);
  a_r1_mixed_sign_add: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !dbl_i && !sub_i && (a_i[W-1] != b_i[W-1]))
      |=> (!sat_o && result_o == $past(a_i + b_i)));

  a_r5_zero_doubled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && dbl_i && b_i == '0) |=> (!sat_o && result_o == $past(a_i)));

  a_r7_pulse_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !sat_o);

  a_r8_q_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o && !q_clr_i) |=> q_o);

  a_r9_clear_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_clr_i && !valid_i) |=> !q_o);

  a_r9_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sat_o |-> q_o);

  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o));
endmodule

bind sat_alu sat_alu_chk #(.W(W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .a_i      (a_i),
  .b_i      (b_i),
  .dbl_i    (dbl_i),
  .sub_i    (sub_i),
  .q_clr_i  (q_clr_i),
  .result_o (result_o),
  .sat_o    (sat_o),
  .q_o      (q_o)
);

// File: tb/tb_sat_alu.sv
module tb_sat_alu;
  localparam int W = 32;
  localparam int NV = 15;

  localparam logic [31:0] V_A [NV] = '{
    32'd5, 32'hFFFF_FFFF, 32'd10, 32'd3, 32'h7FFF_FFFF, 32'h8000_0000,
    32'h8000_0000, 32'h7FFF_FFFF, 32'd0, 32'd1, 32'd10, 32'hFFFF_FFFF,
    32'd0, 32'd5, 32'h8000_0000};
  localparam logic [31:0] V_B [NV] = '{
    32'd7, 32'd1, 32'd3, 32'd10, 32'd1, 32'hFFFF_FFFF,
    32'd1, 32'hFFFF_FFFF, 32'h8000_0000, 32'd3, 32'd3, 32'h4000_0000,
    32'hBFFF_FFFF, 32'hC000_0000, 32'h2000_0000};
  localparam logic V_DBL [NV] = '{0,0,0,0,0,0,0,0,0,1,1,1,1,1,1};
  localparam logic V_SUB [NV] = '{0,0,1,1,0,0,1,1,1,0,1,0,1,0,1};
  localparam logic [31:0] V_R [NV] = '{
    32'd12, 32'd0, 32'd7, 32'hFFFF_FFF9, 32'h7FFF_FFFF, 32'h8000_0000,
    32'h8000_0000, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'd7, 32'd4, 32'h7FFF_FFFE,
    32'h7FFF_FFFF, 32'h8000_0005, 32'h8000_0000};
  localparam logic V_S [NV] = '{0,0,0,0,1,1,1,1,1,0,0,1,1,0,1};
  localparam string V_TAG [NV] = '{
    "R1","R1","R2","R2","R3","R3","R4","R4","R4","R5","R5","R6","R6","R5","R4"};

  logic         clk_i = 0;
  logic         rst_ni = 0;
  logic         valid_i = 0;
  logic [W-1:0] a_i = '0;
  logic [W-1:0] b_i = '0;
  logic         dbl_i = 0;
  logic         sub_i = 0;
  logic         q_clr_i = 0;
  logic [W-1:0] result_o;
  logic         sat_o;
  logic         q_o;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk_i = ~clk_i;

  sat_alu #(.W(W)) dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one request: driven at a falling edge, sampled at the next falling edge
  task automatic req(input logic [31:0] a, input logic [31:0] b,
                     input logic d, input logic s, input logic clr);
    @(negedge clk_i);
    valid_i = 1; a_i = a; b_i = b; dbl_i = d; sub_i = s; q_clr_i = clr;
    @(negedge clk_i);
    valid_i = 0; q_clr_i = 0;
  endtask

  task automatic idle(input logic clr);
    @(negedge clk_i);
    valid_i = 0; q_clr_i = clr;
    @(negedge clk_i);
    q_clr_i = 0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic q_exp;
    logic [31:0] held;
    repeat (3) @(negedge clk_i);
    check("R10 result", result_o, 0);
    check("R10 sat", {31'd0, sat_o}, 0);
    check("R10 q", {31'd0, q_o}, 0);
    rst_ni = 1;

    q_exp = 0;
    for (int i = 0; i < NV; i++) begin
      req(V_A[i], V_B[i], V_DBL[i], V_SUB[i], 0);
      q_exp = q_exp | V_S[i];
      check(V_TAG[i], result_o, V_R[i]);
      check({V_TAG[i], " R7 sat"}, {31'd0, sat_o}, {31'd0, V_S[i]});
      check("R8 q", {31'd0, q_o}, {31'd0, q_exp});
    end

    // R7/R11: idle edge drops pulse and holds result
    held = result_o;
    idle(0);
    check("R7 idle sat", {31'd0, sat_o}, 0);
    check("R11 hold", result_o, held);
    check("R8 q idle", {31'd0, q_o}, 1);

    // R9: clear on idle
    idle(1);
    check("R9 clear", {31'd0, q_o}, 0);

    // R8: non-saturating request leaves q clear
    req(32'd100, 32'd1, 0, 1, 0);
    check("R2 sub", result_o, 32'd99);
    check("R8 q stays 0", {31'd0, q_o}, 0);

    // R6: doubling clamps, final add does not
    req(32'hFFFF_FFFF, 32'h4000_0000, 1, 0, 0);
    check("R6 dbl clamp", result_o, 32'h7FFF_FFFE);
    check("R6 pulse", {31'd0, sat_o}, 1);
    idle(0);
    idle(0);
    check("R8 sticky", {31'd0, q_o}, 1);

    // R9: set beats simultaneous clear
    idle(1);
    check("R9 cleared", {31'd0, q_o}, 0);
    req(32'h7FFF_FFFF, 32'd5, 0, 0, 1);
    check("R9 set wins", {31'd0, q_o}, 1);
    check("R3 clamp", result_o, 32'h7FFF_FFFF);
    // clear with a non-saturating request
    req(32'd1, 32'd1, 0, 0, 1);
    check("R9 clear w/ req", {31'd0, q_o}, 0);
    check("R1 add", result_o, 32'd2);

    // R10: reset mid-run
    req(32'h8000_0000, 32'd1, 0, 1, 0);
    @(negedge clk_i);
    rst_ni = 0;
    #2;
    check("R10 async result", result_o, 0);
    check("R10 async q", {31'd0, q_o}, 0);
    check("R10 async sat", {31'd0, sat_o}, 0);
    @(negedge clk_i);
    rst_ni = 1;
    idle(0);
    finish_run();
  end
endmodule